// File: doc/BRIEF.md
# Optical Black Level Clamp Loop

This block closes a digital feedback loop around an image-sensor converter so that the black level of the picture settles on a programmable target. While a clamp window is open over the shielded columns of a line, each accepted sample is turned into a signed error against the target. The target is held in quarter-LSB units. At the end of the line the errors are averaged, scaled down by a programmable power of two, and subtracted from a correction word. That word drives an offset DAC that sits ahead of the converter.

Samples arrive on a valid/ready stream. The block never applies back-pressure: `s_ready` is held high out of reset, and a sample counts as taken on any cycle with `s_valid` high. The window pulse, the end-of-line strobe and the settings are plain level inputs sampled on each clock. The mean is found by a bit-serial divider that takes `ACC_W` cycles, so end-of-line strobes must be at least `ACC_W + 2` cycles apart. An end-of-line that arrives while a division is still running clears the accumulator and advances the line counter, but it starts no new update.

When the loop is disabled, the clamp-level setting drives the DAC directly as a fixed offset. The loop state is then frozen or cleared as listed below. The update divider lets the correction move only on one line out of every `upd_div + 1`.

Top module: `obc_clamp_loop`

## Requirements
- R1: After reset, `dac_code` equals mid-scale (512 for a 10-bit DAC) and `s_ready` is high.
- R2: A sample is accumulated only on a cycle where `s_valid`, `clamp_win` and `loop_en` are all high. Its error is 4*`s_data` - `clamp_level`, counted in quarter-LSB steps, and may be negative.
- R3: On an update line, the mean error is the sum divided by the sample count, truncated toward zero. The mean is shifted right arithmetically by `gain_shift`, which rounds toward minus infinity. The result is subtracted from the correction, and the new value appears on `dac_code` exactly 22 clock edges after the edge that samples `eol`.
- R4: The correction saturates at 0 and at 1023 and never wraps.
- R5: Every `eol` seen while the loop is enabled advances a line counter. A line is an update line when the counter has reached `upd_div`, and the counter then restarts at zero, so updates fall on every (`upd_div`+1)-th line. The accumulator clears on every `eol`, whether or not that line updates.
- R6: An update line with no accepted samples leaves the correction unchanged.
- R7: While `loop_en` is low, `dac_code` equals `clamp_level` zero-extended. The accumulator and the line counter clear, an update still in flight is discarded, and the correction word is held. Raising `loop_en` again puts the held correction back on `dac_code`.
- R8: At most 255 samples per line are accumulated. Window samples after the 255th are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample stream valid |
| s_ready | output | 1 | Sample stream ready, always high after reset |
| s_data | input | 10 | ADC sample code |
| clamp_win | input | 1 | High over the shielded-pixel window |
| eol | input | 1 | One-cycle end-of-line strobe |
| clamp_level | input | 8 | Black target in quarter-LSB steps (0 to 63.75 LSB) |
| loop_en | input | 1 | Loop enable; low selects the fixed-offset mode |
| upd_div | input | 4 | Update on one line out of every upd_div+1 |
| gain_shift | input | 3 | Right-shift applied to the mean error (0 to 7) |
| dac_code | output | 10 | Offset DAC correction code |

## Verification
The loop is driven with uniform windows above and below the target, which separates the sign convention of the error. A window whose samples differ gives a mean that is not an integer, and so exposes any rounding of the division. Small negative means under a nonzero shift tell floor rounding apart from truncation. A window with gaps in `s_valid`, where the gap cycles carry large sample values, catches any qualification that ignores the handshake. Runs of lines with `upd_div` = 2, an empty window, extreme errors that hit both rails, an over-long window whose late samples differ, and a disable that lands during an update separate the divider, skip, saturation, count-cap and abort behaviours.

// File: rtl/obc_pkg.sv
package obc_pkg;
  typedef enum logic {DV_IDLE, DV_RUN} div_state_e;

  function automatic int unsigned obc_err_w(input int unsigned adc_w);
    return adc_w + 3;
  endfunction
endpackage

// File: rtl/obc_accum.sv
module obc_accum #(
  parameter int ADC_W = 10,
  parameter int LVL_W = 8,
  parameter int CNT_W = 8,
  parameter int ACC_W = 21
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    take,
  input  logic [ADC_W-1:0]        sample,
  input  logic [LVL_W-1:0]        level,
  input  logic                    eol,
  output logic signed [ACC_W-1:0] tot,
  output logic [CNT_W-1:0]        tot_cnt
);
  localparam int ERR_W = obc_pkg::obc_err_w(ADC_W);

  logic signed [ACC_W-1:0] acc;
  logic [CNT_W-1:0]        cnt;
  logic signed [ERR_W-1:0] err;
  logic signed [ACC_W-1:0] add;
  logic                    use_s;
  logic                    full;

  // Sample in quarter-LSB units minus the quarter-LSB target.
  assign err   = $signed({1'b0, sample, 2'b00}) - $signed({{(ERR_W-LVL_W){1'b0}}, level});
  assign full  = &cnt;
  assign use_s = en && take && !full;
  assign add   = use_s ? {{(ACC_W-ERR_W){err[ERR_W-1]}}, err} : '0;
  assign tot     = acc + add;
  assign tot_cnt = cnt + CNT_W'(use_s);

  always_ff @(posedge clk) begin
    if (!rst_n || !en || eol) begin
      acc <= '0;
      cnt <= '0;
    end else begin
      acc <= tot;
      cnt <= tot_cnt;
    end
  end

  // R2: nothing outside a qualified sample changes the running sum.
  a_r2_outside_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !eol && !take && $past(rst_n)) |=> ($stable(acc) && $stable(cnt)));

  // R8: once the count is full, further samples are dropped.
  a_r8_cnt_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !eol && full) |=> ((&cnt) && $stable(acc)));
endmodule

// File: rtl/obc_line_div.sv
module obc_line_div #(
  parameter int DIVSEL_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                eol,
  input  logic [DIVSEL_W-1:0] div_sel,
  output logic                elig
);
  logic [DIVSEL_W-1:0] lcnt;

  assign elig = en && eol && (lcnt >= div_sel);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      lcnt <= '0;
    end else if (eol) begin
      lcnt <= elig ? '0 : lcnt + DIVSEL_W'(1);
    end
  end

  // R5: an update line restarts the line count.
  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    elig |=> (lcnt == '0));

  // R5: a skipped line advances the count by one.
  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && eol && !elig) |=> (lcnt == $past(lcnt) + DIVSEL_W'(1)));
endmodule

// File: rtl/obc_mean_div.sv
module obc_mean_div #(
  parameter int ACC_W = 21,
  parameter int CNT_W = 8,
  parameter int SHF_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    start,
  input  logic signed [ACC_W-1:0] dividend,
  input  logic [CNT_W-1:0]        divisor,
  input  logic [SHF_W-1:0]        shift_in,
  output logic                    busy,
  output logic                    done,
  output logic [ACC_W-1:0]        quo,
  output logic                    neg,
  output logic [SHF_W-1:0]        shift_q
);
  import obc_pkg::*;
  localparam int STEP_W = $clog2(ACC_W + 1);

  div_state_e        st;
  logic [STEP_W-1:0] step;
  logic [CNT_W-1:0]  rem;
  logic [CNT_W-1:0]  dsr;
  logic [ACC_W-1:0]  mag;
  logic [CNT_W:0]    trial;
  logic [CNT_W:0]    trial_sub;
  logic              ge;
  logic              go;

  assign busy = (st == DV_RUN);
  assign go   = en && start && !busy;
  assign mag  = dividend[ACC_W-1] ? (~dividend + ACC_W'(1)) : dividend;

  always_comb begin
    trial     = {rem, quo[ACC_W-1]};
    trial_sub = trial - {1'b0, dsr};
    ge        = (trial >= {1'b0, dsr});
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      st      <= DV_IDLE;
      step    <= '0;
      rem     <= '0;
      dsr     <= '0;
      quo     <= '0;
      neg     <= 1'b0;
      shift_q <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        st      <= DV_RUN;
        step    <= STEP_W'(ACC_W);
        rem     <= '0;
        dsr     <= divisor;
        quo     <= mag;
        neg     <= dividend[ACC_W-1];
        shift_q <= shift_in;
      end else if (busy) begin
        rem  <= ge ? trial_sub[CNT_W-1:0] : trial[CNT_W-1:0];
        quo  <= {quo[ACC_W-2:0], ge};
        step <= step - STEP_W'(1);
        if (step == STEP_W'(1)) begin
          st   <= DV_IDLE;
          done <= 1'b1;
        end
      end
    end
  end

  // R3: the completion flag is a single-cycle pulse.
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3: a division that ends while enabled always reports completion.
  a_r3_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(en)) |-> done);
endmodule

// File: rtl/obc_corr.sv
module obc_corr #(
  parameter int ACC_W = 21,
  parameter int DAC_W = 10,
  parameter int SHF_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             done,
  input  logic [ACC_W-1:0] quo,
  input  logic             neg,
  input  logic [SHF_W-1:0] shift,
  output logic [DAC_W-1:0] corr
);
  localparam int NX_W = ACC_W + 2;
  localparam logic [DAC_W-1:0] MID = DAC_W'(1) << (DAC_W - 1);
  localparam logic signed [NX_W-1:0] TOP = NX_W'((1 << DAC_W) - 1);

  logic signed [ACC_W:0]  mean;
  logic signed [ACC_W:0]  delta;
  logic signed [NX_W-1:0] diff;
  logic [DAC_W-1:0]       nxt;

  always_comb begin
    mean  = neg ? -$signed({1'b0, quo}) : $signed({1'b0, quo});
    delta = mean >>> shift;
    diff  = $signed({{(NX_W-DAC_W){1'b0}}, corr}) - $signed({delta[ACC_W], delta});
    if (diff < 0)        nxt = '0;
    else if (diff > TOP) nxt = {DAC_W{1'b1}};
    else                 nxt = diff[DAC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           corr <= MID;
    else if (en && done)  corr <= nxt;
  end

  // R3: the correction moves only when an update completes.
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(en && done) && $past(rst_n)) |=> $stable(corr));

  // R3/R4: a positive mean never raises the code, a negative one never lowers it.
  a_r4_dir_down: assert property (@(posedge clk) disable iff (!rst_n)
    (en && done && !neg) |=> (corr <= $past(corr)));
  a_r4_dir_up: assert property (@(posedge clk) disable iff (!rst_n)
    (en && done && neg) |=> (corr >= $past(corr)));
endmodule

// File: rtl/obc_clamp_loop.sv
module obc_clamp_loop #(
  parameter int ADC_W    = 10,
  parameter int LVL_W    = 8,
  parameter int DAC_W    = 10,
  parameter int CNT_W    = 8,
  parameter int DIVSEL_W = 4,
  parameter int SHF_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [ADC_W-1:0]    s_data,
  input  logic                clamp_win,
  input  logic                eol,
  input  logic [LVL_W-1:0]    clamp_level,
  input  logic                loop_en,
  input  logic [DIVSEL_W-1:0] upd_div,
  input  logic [SHF_W-1:0]    gain_shift,
  output logic [DAC_W-1:0]    dac_code
);
  localparam int ERR_W = obc_pkg::obc_err_w(ADC_W);
  localparam int ACC_W = ERR_W + CNT_W;

  logic signed [ACC_W-1:0] tot;
  logic [CNT_W-1:0]        tot_cnt;
  logic                    elig;
  logic                    busy;
  logic                    done;
  logic [ACC_W-1:0]        quo;
  logic                    neg;
  logic [SHF_W-1:0]        shift_q;
  logic [DAC_W-1:0]        corr;
  logic                    start;

  assign s_ready = 1'b1;
  assign start   = elig && (tot_cnt != '0);

  obc_accum #(.ADC_W(ADC_W), .LVL_W(LVL_W), .CNT_W(CNT_W), .ACC_W(ACC_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .en(loop_en), .take(s_valid && clamp_win),
    .sample(s_data), .level(clamp_level), .eol(eol),
    .tot(tot), .tot_cnt(tot_cnt));

  obc_line_div #(.DIVSEL_W(DIVSEL_W)) u_line (
    .clk(clk), .rst_n(rst_n), .en(loop_en), .eol(eol),
    .div_sel(upd_div), .elig(elig));

  obc_mean_div #(.ACC_W(ACC_W), .CNT_W(CNT_W), .SHF_W(SHF_W)) u_div (
    .clk(clk), .rst_n(rst_n), .en(loop_en), .start(start),
    .dividend(tot), .divisor(tot_cnt), .shift_in(gain_shift),
    .busy(busy), .done(done), .quo(quo), .neg(neg), .shift_q(shift_q));

  obc_corr #(.ACC_W(ACC_W), .DAC_W(DAC_W), .SHF_W(SHF_W)) u_corr (
    .clk(clk), .rst_n(rst_n), .en(loop_en), .done(done),
    .quo(quo), .neg(neg), .shift(shift_q), .corr(corr));

  // Fixed-offset mode places the clamp level straight on the DAC.
  generate
    if (DAC_W > LVL_W) begin : g_ext
      assign dac_code = loop_en ? corr : {{(DAC_W-LVL_W){1'b0}}, clamp_level};
    end else begin : g_same
      assign dac_code = loop_en ? corr : clamp_level[DAC_W-1:0];
    end
  endgenerate

  // R7: no division survives a disabled cycle.
  a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_en |=> (!busy && !done));

  // R7: the held correction does not drift while disabled.
  a_r7_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_en && $past(rst_n)) |=> $stable(corr));

  // R6: a line with no accepted samples never launches an update.
  a_r6_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (elig && (tot_cnt == '0) && !busy) |=> !busy);
endmodule

// File: tb/obc_clamp_loop_test.sv
module obc_clamp_loop_test;
  localparam int CLK_NS = 10;
  localparam int ACC_W  = 21;
  localparam int LAT    = ACC_W + 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_valid = 1'b0;
  logic       s_ready;
  logic [9:0] s_data = '0;
  logic       clamp_win = 1'b0;
  logic       eol = 1'b0;
  logic [7:0] clamp_level = '0;
  logic       loop_en = 1'b0;
  logic [3:0] upd_div = '0;
  logic [2:0] gain_shift = '0;
  logic [9:0] dac_code;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  string cur_req = "R1";

  int m_acc, m_cnt, m_lcnt, m_corr, m_due, m_delta, edge_n;
  bit m_pend;

  always #(CLK_NS/2) clk = ~clk;

  obc_clamp_loop uut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .clamp_win(clamp_win), .eol(eol),
    .clamp_level(clamp_level), .loop_en(loop_en), .upd_div(upd_div),
    .gain_shift(gain_shift), .dac_code(dac_code));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int floor_shift(int v, int k);
    if (v >= 0) return v >> k;
    return -(((-v) + (1 << k) - 1) >> k);
  endfunction

  function automatic int clip(int v);
    if (v < 0) return 0;
    if (v > 1023) return 1023;
    return v;
  endfunction

  task automatic model_edge();
    int c, inc, tot, tc, mean;
    bit elig;
    edge_n++;
    c = 0; inc = 0;
    if (!rst_n) begin
      m_acc = 0; m_cnt = 0; m_lcnt = 0; m_corr = 512; m_pend = 0;
      return;
    end
    if (!loop_en) begin
      m_acc = 0; m_cnt = 0; m_lcnt = 0; m_pend = 0;
      return;
    end
    if (m_pend && edge_n == m_due) begin
      m_corr = clip(m_corr - m_delta);
      m_pend = 0;
    end
    if (s_valid && clamp_win && m_cnt < 255) begin
      c = 4 * int'(s_data) - int'(clamp_level);
      inc = 1;
    end
    if (eol) begin
      tot = m_acc + c; tc = m_cnt + inc;
      m_acc = 0; m_cnt = 0;
      elig = (m_lcnt >= int'(upd_div));
      m_lcnt = elig ? 0 : m_lcnt + 1;
      if (elig && tc > 0 && !m_pend) begin
        mean = tot / tc;
        m_delta = floor_shift(mean, int'(gain_shift));
        m_pend = 1;
        m_due = edge_n + LAT;
      end
    end else begin
      m_acc += c; m_cnt += inc;
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(cur_req, int'(dac_code), loop_en ? m_corr : int'(clamp_level));
    check("R1", int'(s_ready), 1);
  endtask

  task automatic run_line(int n, int v1, int n1, int v2, bit gaps, int post);
    for (int i = 0; i < n; i++) begin
      clamp_win = 1'b1;
      s_valid = gaps ? (i % 2 == 0) : 1'b1;
      s_data = (gaps && (i % 2 == 1)) ? 10'd1000 : ((i < n1) ? 10'(v1) : 10'(v2));
      cycle();
    end
    clamp_win = 1'b0; s_valid = 1'b1; s_data = 10'd777;  // outside window: ignored (R2)
    cycle(); cycle();
    s_valid = 1'b0; eol = 1'b1;
    cycle();
    eol = 1'b0;
    for (int i = 0; i < post; i++) cycle();
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) cycle();
    rst_n = 1'b1; loop_en = 1'b1;
    cycle();
    check("R1", int'(dac_code), 512);

    cur_req = "R7";
    loop_en = 1'b0; clamp_level = 8'd90;
    cycle();
    check("R7", int'(dac_code), 90);

    cur_req = "R3";
    loop_en = 1'b1; clamp_level = 8'd40;
    run_line(20, 30, 20, 30, 1'b0, 30);
    check("R3", int'(dac_code), 432);
    run_line(20, 5, 20, 5, 1'b0, 30);
    check("R3", int'(dac_code), 452);
    gain_shift = 3'd2;
    run_line(20, 30, 20, 30, 1'b0, 30);
    check("R3", int'(dac_code), 432);
    clamp_level = 8'd43;
    run_line(20, 10, 20, 10, 1'b0, 30);
    check("R3", int'(dac_code), 433);

    cur_req = "R2";
    gain_shift = 3'd0; clamp_level = 8'd40;
    run_line(40, 30, 40, 30, 1'b1, 30);
    check("R2", int'(dac_code), 353);

    cur_req = "R3";
    run_line(21, 30, 10, 31, 1'b0, 30);
    check("R3", int'(dac_code), 271);

    cur_req = "R5";
    upd_div = 4'd2;
    run_line(20, 35, 20, 35, 1'b0, 30);
    check("R5", int'(dac_code), 271);
    run_line(20, 35, 20, 35, 1'b0, 30);
    check("R5", int'(dac_code), 271);
    run_line(20, 35, 20, 35, 1'b0, 30);
    check("R5", int'(dac_code), 171);
    upd_div = 4'd0;

    cur_req = "R6";
    run_line(0, 0, 0, 0, 1'b0, 30);
    check("R6", int'(dac_code), 171);

    cur_req = "R4";
    clamp_level = 8'd0;
    run_line(20, 1023, 20, 1023, 1'b0, 30);
    check("R4", int'(dac_code), 0);
    clamp_level = 8'd255;
    for (int j = 0; j < 5; j++) run_line(20, 0, 20, 0, 1'b0, 30);
    check("R4", int'(dac_code), 1023);

    cur_req = "R8";
    clamp_level = 8'd40;
    run_line(300, 30, 255, 1023, 1'b0, 30);
    check("R8", int'(dac_code), 943);

    cur_req = "R7";
    loop_en = 1'b0; clamp_level = 8'd90;
    run_line(20, 500, 20, 500, 1'b0, 30);
    check("R7", int'(dac_code), 90);
    loop_en = 1'b1; clamp_level = 8'd40;
    cycle();
    check("R7", int'(dac_code), 943);
    run_line(20, 200, 20, 200, 1'b0, 5);
    loop_en = 1'b0;
    repeat (3) cycle();
    loop_en = 1'b1;
    repeat (30) cycle();
    check("R7", int'(dac_code), 943);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule